// File: doc/BRIEF.md
# Cross-Port Mailbox Interrupt Flags

This block sits beside a two-port, 64K-word by 16-bit shared memory and gives the two ports a way to signal each other. The two highest word addresses act as mailboxes. The topmost address belongs to the right port and the one below it belongs to the left port. When one port writes the other port's mailbox, the other port sees its active-low interrupt line fall. The owning port removes the interrupt by reading its own mailbox. The mailbox words stay ordinary storage in the memory, which lies outside this block. The block only watches the control and address lines of each port.

All port controls are sampled on the rising edge of one clock. A write is an access with the port enable and the write strobe both low. A read-clear is an access with the port enable and the output enable both low, whatever the write strobe is. A port's active-low busy input, when low, cancels any notification that port would send. A global feature enable, when low, forces both interrupts inactive. If a notification and a read-clear hit the same flag in the same cycle, the notification wins, so a fresh message is never lost. Each interrupt output comes straight from a flop and changes in the cycle after the rising edge that sampled the access.

Top module: `mbx_irq_top`

## Requirements
- R1: While the reset input is low, and after reset is released until a notifying access is sampled, both `irq_l_n` and `irq_r_n` are 1.
- R2: A left access with `l_sel_n`=0, `l_wr_n`=0, `l_busy_n`=1 and `l_addr`=16'hFFFF, sampled with `feat_en`=1, drives `irq_r_n` to 0 from the next rising edge.
- R3: A right access with `r_sel_n`=0, `r_wr_n`=0, `r_busy_n`=1 and `r_addr`=16'hFFFE, sampled with `feat_en`=1, drives `irq_l_n` to 0 from the next rising edge.
- R4: A right access with `r_sel_n`=0, `r_oe_n`=0 and `r_addr`=16'hFFFF returns `irq_r_n` to 1 at the next rising edge, for `r_wr_n` of either 0 or 1.
- R5: A left access with `l_sel_n`=0, `l_oe_n`=0 and `l_addr`=16'hFFFE returns `irq_l_n` to 1 at the next rising edge, for `l_wr_n` of either 0 or 1.
- R6: When the writing port's busy input is 0, its write to the peer's mailbox leaves the peer's interrupt output unchanged.
- R7: When a notification and a read-clear of the same flag are sampled on the same edge, the interrupt output is 0 after that edge.
- R8: When `feat_en` is 0 on a rising edge, both interrupt outputs are 1 after that edge, whatever the port accesses are.
- R9: Accesses to any other address, accesses with the port enable high, reads of the peer's mailbox, and writes with the output enable high to a port's own mailbox leave both interrupt outputs unchanged.
- R10: With no notification, read-clear or feature disable sampled, each interrupt output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all port controls |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| feat_en | input | 1 | Feature enable; 0 holds both interrupts inactive |
| l_sel_n | input | 1 | Left port enable, active low |
| l_wr_n | input | 1 | Left port write strobe, active low |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | 16 | Left port word address |
| l_busy_n | input | 1 | Left port busy, active low; blocks left notifications |
| r_sel_n | input | 1 | Right port enable, active low |
| r_wr_n | input | 1 | Right port write strobe, active low |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | 16 | Right port word address |
| r_busy_n | input | 1 | Right port busy, active low; blocks right notifications |
| irq_l_n | output | 1 | Interrupt toward the left port, active low |
| irq_r_n | output | 1 | Interrupt toward the right port, active low |

## Verification
The assertions assume that every port control, address and the feature enable is synchronous to `clk`, holds a known value at each rising edge once reset has been released, and stays steady around that edge. The stimulus changes inputs only on falling edges. It holds every port idle while reset is low and through the internal release window. Accesses are directed at both mailbox addresses, at their near neighbours and at random addresses, with busy and the feature enable toggled during those accesses.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

  // Side index used for the generate loop and slot lookup.
  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } mbx_side_e;

  localparam int unsigned MBX_SIDES   = 2;
  localparam int unsigned MBX_ADDR_W  = 16;
  localparam int unsigned MBX_SYNC_ST = 2;

  // Mailbox word owned by a side: right owns the last word, left the one below.
  function automatic logic [31:0] mbx_slot(input int unsigned aw, input mbx_side_e side);
    logic [31:0] last_word;
    last_word = (32'd1 << aw) - 32'd1;
    return (side == SIDE_R) ? last_word : (last_word - 32'd1);
  endfunction

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] OWN_SLOT  = '1,
  parameter logic [ADDR_W-1:0] PEER_SLOT = '0
) (
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy_n,
  output logic              notify_peer,
  output logic              ack_own
);

  logic hit_own;
  logic hit_peer;
  logic is_write;
  logic is_read;

  always_comb begin
    hit_own     = (addr == OWN_SLOT);
    hit_peer    = (addr == PEER_SLOT);
    is_write    = !sel_n && !wr_n;
    is_read     = !sel_n && !oe_n;
    notify_peer = is_write && hit_peer && busy_n;
    ack_own     = is_read && hit_own;
  end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic feat_en,
  input  logic set_req,
  input  logic clr_req,
  output logic pend
);

  logic pend_q;
  logic pend_d;
  logic pend_upd;

  always_comb begin
    pend_upd = !feat_en || set_req || clr_req;
    if (!feat_en) begin
      pend_d = 1'b0;
    end else if (set_req) begin
      pend_d = 1'b1;
    end else if (clr_req) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_upd) begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R2 and R3: a sampled notification raises the flag
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_en && set_req) |=> pend);

  // R7: notification beats a simultaneous clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_en && set_req && clr_req) |=> pend);

  // R4 and R5: a lone read-clear drops the flag
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> !pend);

  // R8: disabled feature leaves nothing pending
  p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!feat_en) |=> !pend);

  // R10: no event, no change
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_en && !set_req && !clr_req) |=> $stable(pend));

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = MBX_ADDR_W,
  parameter int unsigned SYNC_ST = MBX_SYNC_ST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              l_sel_n,
  input  logic              l_wr_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy_n,
  input  logic              r_sel_n,
  input  logic              r_wr_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy_n,
  output logic              irq_l_n,
  output logic              irq_r_n
);

  localparam int unsigned NS = MBX_SIDES;

  logic              rst_q_n;
  logic [NS-1:0]     sel_v;
  logic [NS-1:0]     wr_v;
  logic [NS-1:0]     oe_v;
  logic [NS-1:0]     busy_v;
  logic [ADDR_W-1:0] addr_v [NS];
  logic [NS-1:0]     notify_v;
  logic [NS-1:0]     ack_v;
  logic [NS-1:0]     pend_v;

  always_comb begin
    sel_v  = {r_sel_n,  l_sel_n};
    wr_v   = {r_wr_n,   l_wr_n};
    oe_v   = {r_oe_n,   l_oe_n};
    busy_v = {r_busy_n, l_busy_n};
    addr_v[SIDE_L] = l_addr;
    addr_v[SIDE_R] = r_addr;
  end

  mbx_rst_sync #(.STAGES(SYNC_ST)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  for (genvar p = 0; p < NS; p++) begin : g_side
    localparam mbx_side_e           ME    = mbx_side_e'(p);
    localparam mbx_side_e           OTHER = mbx_side_e'(NS - 1 - p);
    localparam logic [ADDR_W-1:0]   OWN   = ADDR_W'(mbx_slot(ADDR_W, ME));
    localparam logic [ADDR_W-1:0]   PEER  = ADDR_W'(mbx_slot(ADDR_W, OTHER));

    mbx_port_dec #(
      .ADDR_W    (ADDR_W),
      .OWN_SLOT  (OWN),
      .PEER_SLOT (PEER)
    ) u_dec (
      .sel_n       (sel_v[p]),
      .wr_n        (wr_v[p]),
      .oe_n        (oe_v[p]),
      .addr        (addr_v[p]),
      .busy_n      (busy_v[p]),
      .notify_peer (notify_v[p]),
      .ack_own     (ack_v[p])
    );

    mbx_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .feat_en (feat_en),
      .set_req (notify_v[NS-1-p]),
      .clr_req (ack_v[p]),
      .pend    (pend_v[p])
    );
  end

  assign irq_l_n = ~pend_v[SIDE_L];
  assign irq_r_n = ~pend_v[SIDE_R];

  // R1: both lines inactive while the internal reset holds
  p_reset_idle_r1: assert property (@(posedge clk)
    (!rst_q_n) |-> (irq_l_n && irq_r_n));

  // R6: a busy left writer cannot raise the right interrupt
  p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!l_busy_n && irq_r_n) |=> irq_r_n);

  // R6: a busy right writer cannot raise the left interrupt
  p_busy_blocks_l_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!r_busy_n && irq_l_n) |=> irq_l_n);

  // R9: only a left write of the last word can drop the right line
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (irq_r_n && !(!l_sel_n && !l_wr_n && (l_addr == '1))) |=> irq_r_n);

  // R8: feature off forces both lines inactive
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!feat_en) |=> (irq_l_n && irq_r_n));

endmodule

// File: tb/mbx_irq_top_bench.sv
module mbx_irq_top_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        feat_en;
  logic        l_sel_n, l_wr_n, l_oe_n, l_busy_n;
  logic        r_sel_n, r_wr_n, r_oe_n, r_busy_n;
  logic [15:0] l_addr, r_addr;
  logic        irq_l_n, irq_r_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit model_on = 0;
  int ref_l  = 0;
  int ref_r  = 0;

  always #10 clk = ~clk;

  mbx_irq_top u_mbx_irq_top (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en),
    .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
    .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
    .irq_l_n(irq_l_n), .irq_r_n(irq_r_n)
  );

  // Behavioural reference: pending flags as integers, updated per edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      ref_l = 0;
      ref_r = 0;
    end else if (!feat_en) begin
      ref_l = 0;
      ref_r = 0;
    end else begin
      if (!l_sel_n && !l_wr_n && l_busy_n && l_addr == 16'hFFFF) ref_r = 1;
      else if (!r_sel_n && !r_oe_n && r_addr == 16'hFFFF)         ref_r = 0;
      if (!r_sel_n && !r_wr_n && r_busy_n && r_addr == 16'hFFFE) ref_l = 1;
      else if (!l_sel_n && !l_oe_n && l_addr == 16'hFFFE)         ref_l = 0;
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      checks++;
      if (irq_l_n !== (ref_l == 0) || irq_r_n !== (ref_r == 0)) begin
        fails++;
        $display("FAIL model R10: irq_l_n=%b irq_r_n=%b expected %b %b",
                 irq_l_n, irq_r_n, ref_l == 0, ref_r == 0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  task automatic idle();
    l_sel_n = 1; l_wr_n = 1; l_oe_n = 1; l_busy_n = 1; l_addr = 16'h0000;
    r_sel_n = 1; r_wr_n = 1; r_oe_n = 1; r_busy_n = 1; r_addr = 16'h0000;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_irq(input logic exp_l, input logic exp_r, input string tag);
    checks++;
    if (irq_l_n !== exp_l || irq_r_n !== exp_r) begin
      fails++;
      $display("FAIL %s: irq_l_n=%b irq_r_n=%b expected %b %b",
               tag, irq_l_n, irq_r_n, exp_l, exp_r);
    end
  endtask

  task automatic l_write(input logic [15:0] a, input logic busy);
    l_sel_n = 0; l_wr_n = 0; l_oe_n = 1; l_addr = a; l_busy_n = busy;
  endtask

  task automatic r_write(input logic [15:0] a, input logic busy);
    r_sel_n = 0; r_wr_n = 0; r_oe_n = 1; r_addr = a; r_busy_n = busy;
  endtask

  task automatic l_read(input logic [15:0] a, input logic wr);
    l_sel_n = 0; l_wr_n = wr; l_oe_n = 0; l_addr = a;
  endtask

  task automatic r_read(input logic [15:0] a, input logic wr);
    r_sel_n = 0; r_wr_n = wr; r_oe_n = 0; r_addr = a;
  endtask

  initial begin
    rst_n = 0;
    feat_en = 1;
    idle();
    repeat (3) @(negedge clk);
    expect_irq(1, 1, "R1 in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    expect_irq(1, 1, "R1 after release");
    model_on = 1;

    // R2 then R4 (clear with write strobe high and low)
    l_write(16'hFFFF, 1); tick(); idle();
    expect_irq(1, 0, "R2 left notifies right");
    l_read(16'hFFFF, 1); tick(); idle();
    expect_irq(1, 0, "R9 left reads right mailbox");
    r_write(16'hFFFF, 1); tick(); idle();
    expect_irq(1, 0, "R9 right writes own mailbox oe high");
    r_sel_n = 1; r_oe_n = 0; r_addr = 16'hFFFF; tick(); idle();
    expect_irq(1, 0, "R9 right oe without enable");
    r_read(16'hFFFD, 1); tick(); idle();
    expect_irq(1, 0, "R9 right reads other address");
    r_read(16'hFFFF, 1); tick(); idle();
    expect_irq(1, 1, "R4 right read-clear");
    l_write(16'hFFFF, 1); tick(); idle();
    r_read(16'hFFFF, 0); tick(); idle();
    expect_irq(1, 1, "R4 right clear with write strobe low");

    // R3 then R5
    r_write(16'hFFFE, 1); tick(); idle();
    expect_irq(0, 1, "R3 right notifies left");
    l_write(16'hFFFD, 1); tick(); idle();
    expect_irq(0, 1, "R9 left writes other address");
    l_read(16'hFFFE, 1); tick(); idle();
    expect_irq(1, 1, "R5 left read-clear");
    r_write(16'hFFFE, 1); tick(); idle();
    l_read(16'hFFFE, 0); tick(); idle();
    expect_irq(1, 1, "R5 left clear with write strobe low");

    // R6 busy blocks notifications
    l_write(16'hFFFF, 0); tick(); idle();
    expect_irq(1, 1, "R6 left busy blocks");
    r_write(16'hFFFE, 0); tick(); idle();
    expect_irq(1, 1, "R6 right busy blocks");
    l_write(16'hFFFE, 1); tick(); idle();
    expect_irq(1, 1, "R9 left writes own mailbox");

    // R7 set wins over simultaneous clear, both directions at once
    l_write(16'hFFFF, 1); r_read(16'hFFFF, 1); tick(); idle();
    expect_irq(1, 0, "R7 right set wins");
    r_write(16'hFFFE, 1); l_read(16'hFFFE, 1); tick(); idle();
    expect_irq(0, 0, "R7 left set wins");
    tick();
    expect_irq(0, 0, "R10 hold");

    // R8 feature disable
    feat_en = 0; tick();
    expect_irq(1, 1, "R8 disable clears");
    l_write(16'hFFFF, 1); r_write(16'hFFFE, 1); tick(); idle();
    expect_irq(1, 1, "R8 set ignored when disabled");
    feat_en = 1; tick();
    expect_irq(1, 1, "R8 stays clear after re-enable");

    // Mixed traffic against the reference model
    for (int i = 0; i < 3000; i++) begin
      int unsigned pick;
      l_sel_n  = $urandom_range(0, 3) == 0;
      l_wr_n   = $urandom_range(0, 1);
      l_oe_n   = $urandom_range(0, 1);
      l_busy_n = $urandom_range(0, 5) != 0;
      r_sel_n  = $urandom_range(0, 3) == 0;
      r_wr_n   = $urandom_range(0, 1);
      r_oe_n   = $urandom_range(0, 1);
      r_busy_n = $urandom_range(0, 5) != 0;
      pick = $urandom_range(0, 3);
      l_addr = (pick == 0) ? 16'hFFFE : (pick == 1) ? 16'hFFFF : 16'($urandom);
      pick = $urandom_range(0, 3);
      r_addr = (pick == 0) ? 16'hFFFE : (pick == 1) ? 16'hFFFF : 16'($urandom);
      feat_en = $urandom_range(0, 15) != 0;
      tick();
    end
    idle();
    feat_en = 1;
    tick();
    finish_run();
  end

endmodule